// File: doc/BRIEF.md
# Synchronous Burst SRAM

A single-port synchronous SRAM with a two-byte word and a parameterized depth, modelled for simulation and FPGA builds. Every control input, address and write word is sampled on the rising clock edge. An access is opened by one of two address strobes. After that, an internal 2-bit counter on the low address bits walks a four-word burst, while the upper address bits stay where they were loaded. The counter steps in linear or interleaved order, chosen by a strap. A fresh external address may be loaded on any cycle.

A second strap picks how reads come out. In flow-through mode the output register is bypassed, so data follows the access edge (2-1-1-1). In pipelined mode the data passes through that register (3-1-1-1). The bidirectional data bus is split into a read bus and a write bus, plus a drive flag. The drive flag is turned off two edges after a deselect command. An asynchronous output enable masks it. A sleep input freezes the block.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle with `ce_i` high and `adsp_i` or `adsc_i` high loads `addr_i` and accesses it. A cycle opened by `adsp_i` is always a read, even when `adsc_i` or any write control is also high. A cycle opened only by `adsc_i` writes if a write control is active and reads otherwise.
- R2: With `linear_i`=1, each cycle with no strobe and `adv_i`=1 steps the low two address bits by +1 modulo 4 from the loaded value. The upper bits are unchanged.
- R3: With `linear_i`=0 (interleaved), the low two bits are the loaded low bits XOR the step count 0,1,2,3.
- R4: A cycle with no strobe and `adv_i`=0 inside an open burst accesses the same address again.
- R5: With `pipe_i`=0, read data and `drive_o`=1 appear right after the edge that samples the read.
- R6: With `pipe_i`=1, read data and `drive_o`=1 appear one edge later than with `pipe_i`=0.
- R7: `gw_i`=1 writes both bytes, whatever the values of `bwe_i` and `bsel_i`.
- R8: With `gw_i`=0, a write needs `bwe_i`=1 and writes only the lanes whose `bsel_i` bit is set. `bsel_i[0]` selects bits 7:0 and `bsel_i[1]` selects bits 15:8.
- R9: A strobe with `ce_i`=0 deselects the block. `drive_o` stays high through the cycle after the deselect edge and falls after the next edge.
- R10: `oe_i`=0 forces `drive_o` low at once, without a clock. The read pipeline state is unaffected.
- R11: While `sleep_i`=1, commands are ignored, the memory is unchanged and the outputs hold.
- R12: After reset, and whenever `drive_o`=0, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External address |
| adsp_i | input | 1 | Read-only address strobe (has priority) |
| adsc_i | input | 1 | Read/write address strobe |
| adv_i | input | 1 | Burst advance |
| ce_i | input | 1 | Chip enable, sampled with the strobes |
| gw_i | input | 1 | Global write |
| bwe_i | input | 1 | Byte-write enable |
| bsel_i | input | NBYTES | Byte lane selects |
| wdata_i | input | DW | Write data |
| linear_i | input | 1 | 1 = linear burst, 0 = interleaved |
| pipe_i | input | 1 | 1 = pipelined read, 0 = flow-through |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Sleep, freezes the block |
| rdata_o | output | DW | Read data, zero when not driven |
| drive_o | output | 1 | Output drive flag |

## Verification
The hardest state to reach is the deselect hold. The drive flag must stay high for exactly one cycle after the deselect edge, so the bench issues a deselect directly after a live read burst, in both flow-through and pipelined modes. It then checks the flag on each of the next two edges. The interleaved order is checked by writing a burst in interleaved order and reading it back in linear order, so that the permutation shows up in the read data. Write rejection is checked by reading the same address afterwards, including a write attempt during sleep and an ADSP-opened cycle that carries write controls.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_WRITE,
    CYC_DESEL
  } cyc_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode #(
  parameter int unsigned NBYTES = 2
) (
  input  logic              sleep_i,
  input  logic              adsp_i,
  input  logic              adsc_i,
  input  logic              ce_i,
  input  logic              gw_i,
  input  logic              bwe_i,
  input  logic [NBYTES-1:0] bsel_i,
  input  logic              active_i,
  output sram_pkg::cyc_e    cyc_o,
  output logic              load_o,
  output logic [NBYTES-1:0] wmask_o
);
  import sram_pkg::*;

  logic strobe, wr_req;

  assign strobe  = adsp_i | adsc_i;
  assign wmask_o = gw_i ? '1 : (bwe_i ? bsel_i : '0);
  assign wr_req  = |wmask_o;

  always_comb begin
    cyc_o  = CYC_IDLE;
    load_o = 1'b0;
    if (!sleep_i) begin
      if (strobe) begin
        if (!ce_i) begin
          cyc_o = CYC_DESEL;
        end else begin
          load_o = 1'b1;
          // processor strobe always reads
          cyc_o  = (!adsp_i && wr_req) ? CYC_WRITE : CYC_READ;
        end
      end else if (active_i) begin
        cyc_o = wr_req ? CYC_WRITE : CYC_READ;
      end
    end
  end
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned HW = AW - 2;

  logic [HW-1:0] hi_q, hi_n;
  logic [1:0]    base_q, base_n, cnt_q, cnt_n, low;

  always_comb begin
    hi_n   = hi_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    if (load_i) begin
      hi_n   = addr_i[AW-1:2];
      base_n = addr_i[1:0];
      cnt_n  = 2'd0;
    end else if (step_i) begin
      cnt_n = cnt_q + 2'd1;
    end
    low = linear_i ? (base_n + cnt_n) : (base_n ^ cnt_n);
  end

  assign addr_o = {hi_n, low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          live_i,
  input  logic          rd_i,
  input  logic          dsel_i,
  input  logic          pipe_i,
  input  logic          oe_i,
  input  logic [DW-1:0] mem_rd_i,
  output logic          drive_o,
  output logic [DW-1:0] rdata_o
);
  logic          s1_q, s2_q, dsel_q, s1_n;
  logic [DW-1:0] dout_q;

  // flow-through holds one extra cycle on the first deselect
  assign s1_n = rd_i ? 1'b1 : ((dsel_i && !pipe_i && !dsel_q) ? s1_q : 1'b0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      dsel_q <= 1'b0;
      dout_q <= '0;
    end else begin
      dsel_q <= dsel_i;
      if (live_i) begin
        s1_q   <= s1_n;
        s2_q   <= s1_q;
        dout_q <= mem_rd_i;
      end
    end
  end

  assign drive_o = oe_i & (pipe_i ? s2_q : s1_q);
  assign rdata_o = drive_o ? (pipe_i ? dout_q : mem_rd_i) : '0;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter  int unsigned AW     = 8,
  parameter  int unsigned NBYTES = 2,
  parameter  int unsigned BYTE_W = 8,
  localparam int unsigned DW     = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              adsp_i,
  input  logic              adsc_i,
  input  logic              adv_i,
  input  logic              ce_i,
  input  logic              gw_i,
  input  logic              bwe_i,
  input  logic [NBYTES-1:0] bsel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              linear_i,
  input  logic              pipe_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DW-1:0]     rdata_o,
  output logic              drive_o
);
  import sram_pkg::*;

  localparam int unsigned DEPTH = 1 << AW;

  cyc_e              cyc;
  logic              load, access, step, active_q;
  logic [NBYTES-1:0] wmask;
  logic [AW-1:0]     cur_addr, addr_q;
  logic [DW-1:0]     mem_rd;

  sram_cmd_decode #(.NBYTES(NBYTES)) i_decode (
    .sleep_i (sleep_i),
    .adsp_i  (adsp_i),
    .adsc_i  (adsc_i),
    .ce_i    (ce_i),
    .gw_i    (gw_i),
    .bwe_i   (bwe_i),
    .bsel_i  (bsel_i),
    .active_i(active_q),
    .cyc_o   (cyc),
    .load_o  (load),
    .wmask_o (wmask)
  );

  assign access = (cyc == CYC_READ) || (cyc == CYC_WRITE);
  assign step   = access && !load && adv_i;

  sram_burst_ctr #(.AW(AW)) i_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .linear_i(linear_i),
    .addr_i  (addr_i),
    .addr_o  (cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      if (load)                   active_q <= 1'b1;
      else if (cyc == CYC_DESEL)  active_q <= 1'b0;
      if (access) addr_q <= cur_addr;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (cyc == CYC_WRITE && wmask[b])
        lane_mem[cur_addr] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign mem_rd[b*BYTE_W +: BYTE_W] = lane_mem[addr_q];
  end

  sram_out_stage #(.DW(DW)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .live_i  (!sleep_i),
    .rd_i    (cyc == CYC_READ),
    .dsel_i  (cyc == CYC_DESEL),
    .pipe_i  (pipe_i),
    .oe_i    (oe_i),
    .mem_rd_i(mem_rd),
    .drive_o (drive_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          adsp_i,
  input logic          adsc_i,
  input logic          ce_i,
  input logic          sleep_i,
  input logic          pipe_i,
  input logic          oe_i,
  input logic          drive_o,
  input logic [DW-1:0] rdata_o
);
  logic dsel_now, prev_dsel_q, rd_pend_q;

  assign dsel_now = !sleep_i && (adsp_i || adsc_i) && !ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_dsel_q <= 1'b0;
      rd_pend_q   <= 1'b0;
    end else begin
      prev_dsel_q <= dsel_now;
      rd_pend_q   <= adsp_i && ce_i && !sleep_i && pipe_i;
    end
  end

  // R12
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> rdata_o == '0);

  // R10
  oe_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !drive_o);

  // R11
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(drive_o) || !$stable(oe_i) || !$stable(pipe_i)));

  // R5
  flow_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsp_i && ce_i && !sleep_i && !pipe_i) |=> (drive_o || !oe_i || pipe_i));

  // R6
  pipe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_q && !sleep_i && pipe_i) |=> (drive_o || !oe_i || !pipe_i));

  // R9
  dcd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel_now && !prev_dsel_q && drive_o && !pipe_i) |=> (drive_o || !oe_i || pipe_i));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.DW(DW)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .adsp_i (adsp_i),
  .adsc_i (adsc_i),
  .ce_i   (ce_i),
  .sleep_i(sleep_i),
  .pipe_i (pipe_i),
  .oe_i   (oe_i),
  .drive_o(drive_o),
  .rdata_o(rdata_o)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        adsp = 0, adsc = 0, adv = 0, ce = 0, gw = 0, bwe = 0;
  logic [1:0]  bsel = '0;
  logic [15:0] wdata = '0;
  logic        linear = 1'b0, pipe = 1'b1, oe = 1'b1, sleep = 1'b0;
  logic [15:0] rdata;
  logic        drive;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adsp_i(adsp), .adsc_i(adsc),
    .adv_i(adv), .ce_i(ce), .gw_i(gw), .bwe_i(bwe), .bsel_i(bsel),
    .wdata_i(wdata), .linear_i(linear), .pipe_i(pipe), .oe_i(oe),
    .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  typedef struct packed {
    logic        adsp, adsc, ce, adv, gw;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic        drv;
    logic [15:0] dat;
    logic [3:0]  req;
  } vec_t;

  // flow-through, linear order
  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 8'h12, 16'hA000, 1'b0, 16'h0000, 4'd1},  // R1 adsc write
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 16'hA001, 1'b0, 16'h0000, 4'd2},  // R2 -> 13
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 16'hA002, 1'b0, 16'h0000, 4'd2},  // R2 -> 10
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 16'hA003, 1'b0, 16'h0000, 4'd2},  // R2 -> 11
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'h12, 16'h0000, 1'b1, 16'hA000, 4'd5},  // R5 flow read
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA001, 4'd2},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA002, 4'd2},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA003, 4'd2},
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA003, 4'd4},  // R4 hold
    '{1'b1,1'b0,1'b1,1'b0,1'b1, 8'h10, 16'hFFFF, 1'b1, 16'hA002, 4'd1},  // R1 adsp ignores gw
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 8'h11, 16'hFFFF, 1'b1, 16'hA003, 4'd1},  // R1 both strobes
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA003, 4'd9},  // R9 held
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd9},  // R9 off
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'h10, 16'h0000, 1'b1, 16'hA002, 4'd1},  // R1 no write
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 8'h11, 16'h0000, 1'b1, 16'hA003, 4'd1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00, 16'h0000, 1'b1, 16'hA003, 4'd9},
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 16'h0000, 1'b0, 16'h0000, 4'd12} // R12
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic exp_drv, logic [15:0] exp_dat);
    checks++;
    if (drive !== exp_drv || rdata !== exp_dat) begin
      errors++;
      $display("FAIL %s: drive=%b rdata=%h expected drive=%b rdata=%h",
               req, drive, rdata, exp_drv, exp_dat);
    end
  endtask

  task automatic op(logic p, logic c, logic e, logic a, logic g, logic b,
                    logic [1:0] s, logic [7:0] ad, logic [15:0] wd);
    adsp = p; adsc = c; ce = e; adv = a; gw = g; bwe = b; bsel = s;
    addr = ad; wdata = wd;
    tick();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #9;
    check("R12 reset", 1'b0, 16'h0000);
    rst_n = 1'b1;
    tick();
    check("R12 after reset", 1'b0, 16'h0000);

    pipe = 1'b0; linear = 1'b1;
    for (int i = 0; i < NV; i++) begin
      adsp = TBL[i].adsp; adsc = TBL[i].adsc; ce = TBL[i].ce; adv = TBL[i].adv;
      gw = TBL[i].gw; bwe = 1'b0; bsel = 2'b00;
      addr = TBL[i].addr; wdata = TBL[i].wdata;
      tick();
      check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].drv, TBL[i].dat);
    end

    // R3: interleaved write burst from 0x21 -> 21,20,23,22
    linear = 1'b0;
    op(0,1,1,0,1,0,2'b00,8'h21,16'hB000);
    op(0,0,1,1,1,0,2'b00,8'h00,16'hB001);
    op(0,0,1,1,1,0,2'b00,8'h00,16'hB002);
    op(0,0,1,1,1,0,2'b00,8'h00,16'hB003);
    // R6: pipelined linear read from 0x20
    pipe = 1'b1; linear = 1'b1;
    op(1,0,1,0,0,0,2'b00,8'h20,16'h0);
    check("R6 no data yet", 1'b0, 16'h0000);
    op(0,0,1,1,0,0,2'b00,8'h00,16'h0);
    check("R3 R6 word 20", 1'b1, 16'hB001);
    op(0,0,1,1,0,0,2'b00,8'h00,16'h0);
    check("R3 word 21", 1'b1, 16'hB000);
    oe = 1'b0; #1;
    check("R10 oe low", 1'b0, 16'h0000);
    oe = 1'b1; #1;
    check("R10 oe restored", 1'b1, 16'hB000);
    op(0,0,1,1,0,0,2'b00,8'h00,16'h0);
    check("R3 word 22", 1'b1, 16'hB003);
    op(0,0,1,0,0,0,2'b00,8'h00,16'h0);
    check("R3 word 23", 1'b1, 16'hB002);
    op(0,1,0,0,0,0,2'b00,8'h00,16'h0);
    check("R9 pipe held", 1'b1, 16'hB002);
    op(0,0,0,0,0,0,2'b00,8'h00,16'h0);
    check("R9 pipe off", 1'b0, 16'h0000);

    // byte and global writes, flow-through
    pipe = 1'b0;
    op(0,1,1,0,1,0,2'b00,8'h30,16'h1234);
    op(0,1,1,0,0,1,2'b01,8'h30,16'hABCD);
    op(1,0,1,0,0,0,2'b00,8'h30,16'h0);
    check("R8 low lane", 1'b1, 16'h12CD);
    op(0,1,1,0,0,0,2'b11,8'h30,16'hFFFF);
    check("R8 no bwe reads", 1'b1, 16'h12CD);
    op(0,1,1,0,0,1,2'b10,8'h30,16'hEEEE);
    op(1,0,1,0,0,0,2'b00,8'h30,16'h0);
    check("R8 high lane", 1'b1, 16'hEECD);
    op(0,1,1,0,1,0,2'b00,8'h30,16'h5678);
    op(1,0,1,0,0,0,2'b00,8'h30,16'h0);
    check("R7 global write", 1'b1, 16'h5678);

    // R11: sleep ignores a write
    sleep = 1'b1;
    op(0,1,1,0,1,0,2'b00,8'h30,16'h0000);
    check("R11 sleep hold", 1'b1, 16'h5678);
    op(0,1,0,0,0,0,2'b00,8'h00,16'h0);
    check("R11 sleep no deselect", 1'b1, 16'h5678);
    sleep = 1'b0;
    op(1,0,1,0,0,0,2'b00,8'h30,16'h0);
    check("R11 memory kept", 1'b1, 16'h5678);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule